// File: doc/BRIEF.md
# Parallel Tree Sum Reducer

This block adds up to `MAX_N` signed integers held in an internal bank of registers. It behaves like a group of workers that combine their partial sums in halving rounds. Software, or a neighbouring block, first fills the bank through an indexed write port. It then pulses `start` with an element count. The block steps through rounds on its own. Each round opens with a barrier cycle in which nothing moves. When the working count is odd, an extra cycle folds the stray top element into element 0. A split cycle then halves the count and adds the upper half onto the lower half, all in parallel. When the count reaches one, the total sits in element 0 and `done` goes high.

The element 0 register is always visible on `result`, so the total can be read as soon as `done` rises. The current working count is exported on `half_cnt`, which lets the caller follow the progress of the rounds.

Top module: `tree_sum_reducer`

## Requirements
- R1: After a synchronous active-low reset, `done` is 0, `half_cnt` is 0, every element is 0, and therefore `result` is 0.
- R2: While the block is idle or done, a cycle with `wr_en` high writes `wr_data` into element `wr_idx` at the clock edge; `result` always shows element 0.
- R3: A `start` pulse seen while idle or done loads the working count from `n_elems` and drops `done`, except when the loaded count is 1.
- R4: Every round begins with exactly one barrier cycle in which the working count and all elements keep their values.
- R5: When the working count h is odd and above 1, the cycle after the barrier adds element h-1 into element 0, and only this element changes; the split follows in the next cycle.
- R6: In a split cycle the working count becomes floor(h/2) = m, and every element i < m becomes element i plus element i+m, all in the same edge.
- R7: When the working count reaches 1, `done` rises and `result` equals the sum of the first n loaded elements. With the count running through h = n, floor(n/2), ... down to 2, `done` is visible 2 + (h mod 2) cycles per round after the start edge.
- R8: A count of 1 gives `done` in the cycle right after the start edge, with `result` equal to element 0 unchanged.
- R9: A `start` pulse while a reduction is running is ignored: the total and the latency are those of the running job.
- R10: Writes on the load port while a reduction is running are ignored.
- R11: Elements are 32-bit two's complement, and every add wraps modulo 2^32.
- R12: A count of 0 is handled as 1, and a count above `MAX_N` is handled as `MAX_N`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the element bank |
| wr_idx | input | 7 | Index of the element to write |
| wr_data | input | 32 | Value to write |
| start | input | 1 | Start pulse for a reduction |
| n_elems | input | 8 | Number of elements to reduce |
| result | output | 32 | Current value of element 0 |
| done | output | 1 | High from completion until the next accepted start |
| half_cnt | output | 8 | Current working count |

## Verification
Element 0 is the one register that takes two additions in a round with an odd count. The stray element h-1 is added to it, and its own split partner is also added to it. The block puts these two additions in different cycles, with the stray add one cycle before the split. The bench provokes this with a count of 5. It samples `result` after the barrier, after the stray add and after the split. It expects first e0, then e0+e4, then e0+e4+e2, so a merged or dropped add shows up as a wrong intermediate value. Starts and writes that collide with a running reduction are judged by the final total and the latency.

// File: rtl/tree_sum_pkg.sv
// Package: shared types for the tree sum reducer.
// Assumes: nothing beyond IEEE 1800-2017.
package tree_sum_pkg;
    // Phases of one reduction round plus the resting states.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SYNC  = 3'd1,
        PH_STRAY = 3'd2,
        PH_SPLIT = 3'd3,
        PH_FIN   = 3'd4
    } phase_t;
endpackage

// File: rtl/tree_sum_seq.sv
// Module: round sequencer. Holds the working count and steps through the
// barrier, stray-fold and split phases until the count reaches one.
// Assumes: start is a single-cycle pulse; n_elems may be out of range and is clamped.
module tree_sum_seq
    import tree_sum_pkg::*;
#(
    parameter int MAX_N = 128,
    localparam int CNTW = $clog2(MAX_N + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [CNTW-1:0] n_elems,
    output logic            accept_wr,
    output logic            stray_fire,
    output logic            split_fire,
    output logic [CNTW-1:0] half_q,
    output logic [CNTW-1:0] half_nx,
    output logic            fin
);
    phase_t          phase;
    logic [CNTW-1:0] n_eff;
    logic            busy;

    // Clamp the requested count into 1..MAX_N.
    always_comb begin
        if (n_elems == '0)
            n_eff = CNTW'(1);
        else if (n_elems > CNTW'(MAX_N))
            n_eff = CNTW'(MAX_N);
        else
            n_eff = n_elems;
    end

    // Decode the phase into strobes for the bank.
    always_comb begin
        busy       = (phase == PH_SYNC) || (phase == PH_STRAY) || (phase == PH_SPLIT);
        accept_wr  = !busy;
        stray_fire = (phase == PH_STRAY);
        split_fire = (phase == PH_SPLIT);
        fin        = (phase == PH_FIN);
        half_nx    = half_q >> 1;
    end

    // Phase and working count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            half_q <= '0;
        end else begin
            case (phase)
                PH_IDLE, PH_FIN: begin
                    if (start) begin
                        half_q <= n_eff;
                        phase  <= (n_eff == CNTW'(1)) ? PH_FIN : PH_SYNC;
                    end
                end
                PH_SYNC:  phase <= half_q[0] ? PH_STRAY : PH_SPLIT;
                PH_STRAY: phase <= PH_SPLIT;
                PH_SPLIT: begin
                    half_q <= half_nx;
                    phase  <= (half_nx == CNTW'(1)) ? PH_FIN : PH_SYNC;
                end
                default:  phase <= PH_IDLE;
            endcase
        end
    end

    AST_STRAY_ONLY_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        stray_fire |-> half_q[0]); // R5
    AST_STRAY_THEN_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        stray_fire |=> split_fire); // R5
    AST_SPLIT_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
        split_fire |=> (half_q == ($past(half_q) >> 1))); // R6
    AST_SYNC_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SYNC) |=> (stray_fire || split_fire)); // R4
    AST_FIN_AT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> (half_q == CNTW'(1))); // R7
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (half_q <= $past(half_q))); // R9
endmodule

// File: rtl/tree_sum_lane.sv
// Module: one element register. It loads from the write port or adds a
// partner value in place, with 32-bit wraparound.
// Assumes: the write hit and the add enable are never high together.
module tree_sum_lane #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hit,
    input  logic [W-1:0] wr_data,
    input  logic         add_en,
    input  logic [W-1:0] partner,
    output logic [W-1:0] val
);
    // Element storage: load, accumulate or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            val <= '0;
        else if (wr_hit)
            val <= wr_data;
        else if (add_en)
            val <= val + partner;
    end

    AST_NO_LOAD_DURING_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_hit && add_en)); // R10
endmodule

// File: rtl/tree_sum_bank.sv
// Module: register bank of MAX_N lanes. It routes to each lane its split
// partner, and to lane 0 the stray element during a fold.
// Assumes: half_q lies in 1..MAX_N whenever a fold or split strobe is high.
module tree_sum_bank #(
    parameter int MAX_N = 128,
    parameter int W     = 32,
    localparam int IDXW = $clog2(MAX_N),
    localparam int CNTW = $clog2(MAX_N + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept_wr,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [W-1:0]    wr_data,
    input  logic            stray_fire,
    input  logic            split_fire,
    input  logic [CNTW-1:0] half_q,
    input  logic [CNTW-1:0] half_nx,
    output logic [W-1:0]    head
);
    logic [W-1:0]    elem [MAX_N];
    logic [IDXW-1:0] stray_idx;
    logic [W-1:0]    stray_val;

    // Select the stray top element for an odd-count fold.
    always_comb begin
        stray_idx = IDXW'(half_q - CNTW'(1));
        stray_val = elem[stray_idx];
    end

    for (genvar i = 0; i < MAX_N; i++) begin : g_lane
        logic [CNTW-1:0] pidx;
        logic [W-1:0]    split_val;
        logic [W-1:0]    partner;
        logic            add_en;
        logic            wr_hit;

        // Pick this lane's partner and decide whether it adds this cycle.
        always_comb begin
            pidx      = CNTW'(i) + half_nx;
            split_val = (pidx < CNTW'(MAX_N)) ? elem[IDXW'(pidx)] : '0;
            if (i == 0 && stray_fire) begin
                partner = stray_val;
                add_en  = 1'b1;
            end else begin
                partner = split_val;
                add_en  = split_fire && (CNTW'(i) < half_nx);
            end
            wr_hit = wr_en && accept_wr && (wr_idx == IDXW'(i));
        end

        tree_sum_lane #(.W(W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (wr_hit),
            .wr_data (wr_data),
            .add_en  (add_en),
            .partner (partner),
            .val     (elem[i])
        );
    end

    assign head = elem[0];

    AST_FOLD_HITS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        stray_fire |=> (head == $past(head) + $past(stray_val))); // R5
endmodule

// File: rtl/tree_sum_reducer.sv
// Module: top of the tree sum reducer. It joins the round sequencer
// to the element bank.
// Assumes: MAX_N is a power of two, at least 2.
module tree_sum_reducer #(
    parameter int MAX_N = 128,
    parameter int W     = 32,
    localparam int IDXW = $clog2(MAX_N),
    localparam int CNTW = $clog2(MAX_N + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [W-1:0]    wr_data,
    input  logic            start,
    input  logic [CNTW-1:0] n_elems,
    output logic [W-1:0]    result,
    output logic            done,
    output logic [CNTW-1:0] half_cnt
);
    logic            accept_wr;
    logic            stray_fire;
    logic            split_fire;
    logic [CNTW-1:0] half_q;
    logic [CNTW-1:0] half_nx;

    tree_sum_seq #(.MAX_N(MAX_N)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .n_elems    (n_elems),
        .accept_wr  (accept_wr),
        .stray_fire (stray_fire),
        .split_fire (split_fire),
        .half_q     (half_q),
        .half_nx    (half_nx),
        .fin        (done)
    );

    tree_sum_bank #(.MAX_N(MAX_N), .W(W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_wr  (accept_wr),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .stray_fire (stray_fire),
        .split_fire (split_fire),
        .half_q     (half_q),
        .half_nx    (half_nx),
        .head       (result)
    );

    assign half_cnt = half_q;

    AST_RESULT_HELD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wr_en) |=> $stable(result)); // R7
endmodule

// File: tb/tree_sum_reducer_tb.sv
module tree_sum_reducer_tb;
    localparam int MAX_N = 128;
    localparam int W     = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [6:0]    wr_idx = '0;
    logic [W-1:0]  wr_data = '0;
    logic          start = 1'b0;
    logic [7:0]    n_elems = '0;
    logic [W-1:0]  result;
    logic          done;
    logic [7:0]    half_cnt;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] mdl [MAX_N];

    always #5 clk = ~clk;

    tree_sum_reducer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .start(start), .n_elems(n_elems),
        .result(result), .done(done), .half_cnt(half_cnt)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_lat(input int n);
        int h = n;
        int c = 0;
        while (h > 1) begin
            c += 2 + (h % 2);
            h = h / 2;
        end
        return c;
    endfunction

    function automatic logic [W-1:0] exp_sum(input int n);
        logic [W-1:0] s = '0;
        for (int i = 0; i < n; i++) s += mdl[i];
        return s;
    endfunction

    task automatic load_all();
        for (int i = 0; i < MAX_N; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_idx = 7'(i); wr_data = mdl[i];
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Pulse start; leaves the bench at the negedge right after the start edge.
    task automatic kick(input int n);
        @(negedge clk);
        start = 1'b1; n_elems = 8'(n);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int lat);
        lat = 0;
        while (!done && lat < 2000) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic t_reset();
        chk("R1 done", done, 0);
        chk("R1 half", half_cnt, 0);
        chk("R1 result", result, 0);
    endtask

    task automatic t_load();
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 0; wr_data = 32'h1234_5678;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R2 write elem0", result, 32'h1234_5678);
    endtask

    task automatic t_even();
        int lat;
        for (int i = 0; i < MAX_N; i++) mdl[i] = 32'(i + 1);
        load_all();
        kick(8);
        chk("R3 done dropped", done, 0);
        chk("R3 half loaded", half_cnt, 8);
        wait_done(lat);
        chk("R6/R7 even total", result, exp_sum(8));
        chk("R7 even latency", lat, exp_lat(8));
        chk("R7 half at end", half_cnt, 1);
    endtask

    task automatic t_odd_trace();
        int lat;
        for (int i = 0; i < MAX_N; i++) mdl[i] = 32'(10 * (i + 1));
        load_all();
        kick(5);
        chk("R4 sync half", half_cnt, 5);
        chk("R4 sync result", result, 10);
        @(negedge clk);
        chk("R4 barrier holds", result, 10);
        @(negedge clk);
        chk("R5 stray folded", result, 60);
        chk("R5 half kept", half_cnt, 5);
        @(negedge clk);
        chk("R6 split result", result, 90);
        chk("R6 split half", half_cnt, 2);
        @(negedge clk);
        chk("R4 second barrier", result, 90);
        wait_done(lat);
        chk("R7 odd total", result, 150);
        chk("R7 odd latency", lat + 4, exp_lat(5));
    endtask

    task automatic t_single();
        int lat;
        mdl[0] = 32'hCAFE_0001;
        load_all();
        kick(1);
        wait_done(lat);
        chk("R8 single latency", lat, 0);
        chk("R8 single result", result, 32'hCAFE_0001);
    endtask

    task automatic t_wide();
        int lat;
        for (int i = 0; i < MAX_N; i++) mdl[i] = 32'(i * 7919 + 3) ^ 32'h5A5A_0000;
        load_all();
        kick(100);
        wait_done(lat);
        chk("R7 n100 total", result, exp_sum(100));
        chk("R7 n100 latency", lat, exp_lat(100));
        load_all();
        kick(127);
        wait_done(lat);
        chk("R7 n127 total", result, exp_sum(127));
        chk("R7 n127 latency", lat, exp_lat(127));
    endtask

    task automatic t_wrap();
        int lat;
        mdl[0] = 32'hFFFF_FFFF; mdl[1] = 32'h0000_0002; mdl[2] = 32'h8000_0000;
        load_all();
        kick(3);
        wait_done(lat);
        chk("R11 wrap total", result, 32'h8000_0001);
    endtask

    task automatic t_busy();
        int lat;
        for (int i = 0; i < MAX_N; i++) mdl[i] = 32'(i * 3 + 1);
        load_all();
        kick(16);
        start = 1'b1; n_elems = 8'd2;
        wr_en = 1'b1; wr_idx = 0; wr_data = 32'h0BAD_0BAD;
        @(negedge clk);
        start = 1'b0;
        wr_idx = 7'd9;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R9 half not reloaded", half_cnt == 8'd2 || half_cnt == 8'd16 || half_cnt == 8'd8, 1);
        wait_done(lat);
        chk("R9/R10 total intact", result, exp_sum(16));
        chk("R9 latency intact", lat + 2, exp_lat(16));
    endtask

    task automatic t_clamp();
        int lat;
        for (int i = 0; i < MAX_N; i++) mdl[i] = 32'(i * i + 5);
        load_all();
        kick(0);
        wait_done(lat);
        chk("R12 zero as one latency", lat, 0);
        chk("R12 zero as one result", result, mdl[0]);
        kick(200);
        chk("R12 clamp half", half_cnt, MAX_N);
        wait_done(lat);
        chk("R12 clamp total", result, exp_sum(MAX_N));
        chk("R12 clamp latency", lat, exp_lat(MAX_N));
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < MAX_N; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_even();
        t_odd_trace();
        t_single();
        t_wide();
        t_wrap();
        t_busy();
        t_clamp();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule